// File: doc/BRIEF.md
# Border and Display-Window Raster Timing Generator

This block produces the raster timing for a display whose picture is built from two nested regions. A programmable border rectangle is drawn in a single border colour. A display window sits inside it and starts at a programmable position. Everything outside the border is the sync and blanking interval. Horizontal and vertical counters drive region flags, window-relative pixel and line coordinates, field parity and sync pulses. A downstream pixel fetcher and a video encoder use these outputs.

Software programs the block through a plain register write port. Every write lands in a shadow copy. The whole shadow set is copied into the active set only while the counters sit at the first position of vertical retrace, so mode, pan and blanking changes never tear a visible field. Blanking does not gate the sync pulses. It suppresses the window, so the border colour covers the whole visible raster. Interlace, line doubling, pixel doubling and a full-rate or half-rate pixel step are mode bits.

Top module: `bwin_timing`

## Requirements
- R1: While rst_n is low, and on the first sampled cycle after it, the counters, field parity, region flags, coordinates, border colour and sync outputs are all zero.
- R2: Register 0 holds the clock total in bits 15:0 and the line total in bits 31:16. On each pixel step the horizontal counter goes up by one, and it returns to 0 on a step taken at or above the clock total. That wrap advances the vertical counter, which returns to 0 after its last line.
- R3: Register 7 bit 23 set makes pix_step high on every cycle. When it is clear, pix_step alternates, starting low on the first cycle after reset. Counters hold on cycles without a step.
- R4: Registers 1 and 2 each hold a border start in bits 31:16 and a border stop in bits 15:0 (horizontal, vertical). border_active is high only when register 7 bit 0 is set and start <= counter < stop on both axes.
- R5: Register 3 bits 15:0 give the window horizontal start. Register 4 gives the vertical start for field 0 in bits 15:0 and for field 1 in bits 31:16. window_active is high only when border_active is high and both counters are at or past the window start for the current field.
- R6: Register 6 bit 3 forces window_active low while border_active is unaffected.
- R7: win_x is hcount minus the window horizontal start, halved when register 6 bit 0 is set. It is 0 whenever window_active is low.
- R8: win_y is vcount minus the window vertical start, halved when register 7 bit 1 is set. It is 0 whenever window_active is low.
- R9: With register 8 bit 4 set, field_odd toggles at every field wrap. Field 0 runs lines 0 to the line total and field 1 runs one line fewer. With the bit clear, field_odd becomes 0 at the next field wrap.
- R10: hsync is high when register 8 bit 8 is set and hcount < HSYNC_CLKS. vsync is high when that bit is set and vcount < VSYNC_LINES.
- R11: Writes go to shadow registers. The active set copies the complete shadow set on a clock edge where hcount is 0 and vcount equals the active vertical border stop. Writes to addresses 9 to 15 have no effect.
- R12: border_rgb presents bits 23:0 of active register 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register index |
| cfg_wdata | input | 32 | Register write data |
| hcount | output | CNT_W | Horizontal position |
| vcount | output | CNT_W | Vertical position |
| pix_step | output | 1 | Counters advance at the coming edge |
| field_odd | output | 1 | Field parity |
| border_active | output | 1 | Inside the border rectangle |
| window_active | output | 1 | Inside the display window |
| win_x | output | CNT_W | Window-relative pixel index |
| win_y | output | CNT_W | Window-relative line index |
| border_rgb | output | 24 | Active border colour |
| hsync | output | 1 | Horizontal sync pulse |
| vsync | output | 1 | Vertical sync pulse |

## Verification
A wrong counter or phase state shows up at once on hcount, vcount or pix_step, and it shifts every region flag on the same line. A wrong shadow-to-active transfer stays hidden until the next retrace start. After that it shows on the next visible line as wrong border edges, window offsets, colour or sync behaviour. A field parity error shows only at the following field wrap, as a window starting on the wrong line or a field of the wrong length. For that reason the bench runs several complete fields per configuration.

// File: rtl/bwin_pkg.sv
package bwin_pkg;
  localparam int NUM_REGS = 9;
  localparam int REG_W    = 32;

  typedef enum logic [3:0] {
    RA_TOTALS = 4'd0,
    RA_HBRD   = 4'd1,
    RA_VBRD   = 4'd2,
    RA_WINH   = 4'd3,
    RA_WINV   = 4'd4,
    RA_COLOR  = 4'd5,
    RA_WINCFG = 4'd6,
    RA_MODE   = 4'd7,
    RA_SYNC   = 4'd8
  } reg_addr_e;

  localparam int WINCFG_PIXDBL = 0;
  localparam int WINCFG_BLANK  = 3;
  localparam int MODE_DISP     = 0;
  localparam int MODE_LINEDBL  = 1;
  localparam int MODE_FULLRATE = 23;
  localparam int SYNC_ILACE    = 4;
  localparam int SYNC_VIDEN    = 8;

  typedef struct packed {
    logic [15:0] htot;
    logic [15:0] vtot;
    logic [15:0] hbs;
    logic [15:0] hbe;
    logic [15:0] vbs;
    logic [15:0] vbe;
    logic [15:0] winh;
    logic [15:0] winv0;
    logic [15:0] winv1;
    logic [23:0] color;
    logic        pixdbl;
    logic        blank;
    logic        disp_en;
    logic        line_dbl;
    logic        full_rate;
    logic        vid_en;
    logic        ilace;
  } cfg_t;

  function automatic cfg_t decode_cfg(input logic [NUM_REGS-1:0][REG_W-1:0] r);
    cfg_t c;
    c.htot      = r[RA_TOTALS][15:0];
    c.vtot      = r[RA_TOTALS][31:16];
    c.hbs       = r[RA_HBRD][31:16];
    c.hbe       = r[RA_HBRD][15:0];
    c.vbs       = r[RA_VBRD][31:16];
    c.vbe       = r[RA_VBRD][15:0];
    c.winh      = r[RA_WINH][15:0];
    c.winv0     = r[RA_WINV][15:0];
    c.winv1     = r[RA_WINV][31:16];
    c.color     = r[RA_COLOR][23:0];
    c.pixdbl    = r[RA_WINCFG][WINCFG_PIXDBL];
    c.blank     = r[RA_WINCFG][WINCFG_BLANK];
    c.disp_en   = r[RA_MODE][MODE_DISP];
    c.line_dbl  = r[RA_MODE][MODE_LINEDBL];
    c.full_rate = r[RA_MODE][MODE_FULLRATE];
    c.vid_en    = r[RA_SYNC][SYNC_VIDEN];
    c.ilace     = r[RA_SYNC][SYNC_ILACE];
    return c;
  endfunction
endpackage

// File: rtl/bwin_regs.sv
module bwin_regs #(
  parameter int NREG   = 9,
  parameter int ADDR_W = 4,
  parameter int DW     = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DW-1:0]             wr_data,
  input  logic                      load,
  output logic [NREG-1:0][DW-1:0]   shadow_q,
  output logic [NREG-1:0][DW-1:0]   active_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wr_en && (wr_addr == ADDR_W'(i))) shadow_q[i] <= wr_data;
        if (load) active_q[i] <= shadow_q[i];
      end
    end
  end
endmodule

// File: rtl/bwin_counters.sv
module bwin_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] htot,
  input  logic [CNT_W-1:0] vtot,
  input  logic             full_rate,
  input  logic             ilace,
  output logic [CNT_W-1:0] hcnt,
  output logic [CNT_W-1:0] vcnt,
  output logic             field,
  output logic             step
);
  logic             phase;
  logic [CNT_W-1:0] vlast;
  logic             h_end;
  logic             v_end;

  assign step  = full_rate | phase;
  assign vlast = (ilace && field && (vtot != '0)) ? vtot - 1'b1 : vtot;
  assign h_end = (hcnt >= htot);
  assign v_end = (vcnt >= vlast);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 1'b0;
      hcnt  <= '0;
      vcnt  <= '0;
      field <= 1'b0;
    end else begin
      phase <= ~phase;
      if (step) begin
        if (h_end) begin
          hcnt <= '0;
          if (v_end) begin
            vcnt  <= '0;
            field <= ilace ? ~field : 1'b0;
          end else begin
            vcnt <= vcnt + 1'b1;
          end
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bwin_regions.sv
module bwin_regions #(
  parameter int CNT_W       = 16,
  parameter int HSYNC_CLKS  = 8,
  parameter int VSYNC_LINES = 2
) (
  input  logic [CNT_W-1:0] hcnt,
  input  logic [CNT_W-1:0] vcnt,
  input  logic             field,
  input  logic [CNT_W-1:0] hbs,
  input  logic [CNT_W-1:0] hbe,
  input  logic [CNT_W-1:0] vbs,
  input  logic [CNT_W-1:0] vbe,
  input  logic [CNT_W-1:0] winh,
  input  logic [CNT_W-1:0] winv0,
  input  logic [CNT_W-1:0] winv1,
  input  logic             disp_en,
  input  logic             blank,
  input  logic             pixdbl,
  input  logic             line_dbl,
  input  logic             vid_en,
  output logic             border_act,
  output logic             win_act,
  output logic [CNT_W-1:0] win_x,
  output logic [CNT_W-1:0] win_y,
  output logic             hsync,
  output logic             vsync
);
  logic             in_h, in_v;
  logic [CNT_W-1:0] winv;
  logic [CNT_W-1:0] dx, dy;

  assign in_h       = (hcnt >= hbs) && (hcnt < hbe);
  assign in_v       = (vcnt >= vbs) && (vcnt < vbe);
  assign border_act = disp_en && in_h && in_v;
  assign winv       = field ? winv1 : winv0;
  assign win_act    = border_act && !blank && (hcnt >= winh) && (vcnt >= winv);
  assign dx         = hcnt - winh;
  assign dy         = vcnt - winv;

  always_comb begin
    win_x = '0;
    win_y = '0;
    if (win_act) begin
      win_x = pixdbl   ? (dx >> 1) : dx;
      win_y = line_dbl ? (dy >> 1) : dy;
    end
  end

  assign hsync = vid_en && (hcnt < CNT_W'(HSYNC_CLKS));
  assign vsync = vid_en && (vcnt < CNT_W'(VSYNC_LINES));
endmodule

// File: rtl/bwin_timing.sv
module bwin_timing
  import bwin_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 4,
  parameter int HSYNC_CLKS  = 8,
  parameter int VSYNC_LINES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [CNT_W-1:0]  hcount,
  output logic [CNT_W-1:0]  vcount,
  output logic              pix_step,
  output logic              field_odd,
  output logic              border_active,
  output logic              window_active,
  output logic [CNT_W-1:0]  win_x,
  output logic [CNT_W-1:0]  win_y,
  output logic [23:0]       border_rgb,
  output logic              hsync,
  output logic              vsync
);
  logic [NUM_REGS-1:0][REG_W-1:0] shadow_img;
  logic [NUM_REGS-1:0][REG_W-1:0] active_img;
  cfg_t                           cfg;
  logic                           load;
  logic [CNT_W-1:0]               htot_a;
  logic [CNT_W-1:0]               vbe_a;
  logic                           blank_a;
  logic                           vid_en_a;
  logic                           full_rate_a;

  assign cfg         = decode_cfg(active_img);
  assign htot_a      = cfg.htot[CNT_W-1:0];
  assign vbe_a       = cfg.vbe[CNT_W-1:0];
  assign blank_a     = cfg.blank;
  assign vid_en_a    = cfg.vid_en;
  assign full_rate_a = cfg.full_rate;
  assign load        = (hcount == '0) && (vcount == vbe_a);
  assign border_rgb  = cfg.color;

  bwin_regs #(.NREG(NUM_REGS), .ADDR_W(ADDR_W), .DW(REG_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_addr  (cfg_addr),
    .wr_data  (cfg_wdata),
    .load     (load),
    .shadow_q (shadow_img),
    .active_q (active_img)
  );

  bwin_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .htot      (htot_a),
    .vtot      (cfg.vtot[CNT_W-1:0]),
    .full_rate (full_rate_a),
    .ilace     (cfg.ilace),
    .hcnt      (hcount),
    .vcnt      (vcount),
    .field     (field_odd),
    .step      (pix_step)
  );

  bwin_regions #(.CNT_W(CNT_W), .HSYNC_CLKS(HSYNC_CLKS), .VSYNC_LINES(VSYNC_LINES)) u_reg_dec (
    .hcnt       (hcount),
    .vcnt       (vcount),
    .field      (field_odd),
    .hbs        (cfg.hbs[CNT_W-1:0]),
    .hbe        (cfg.hbe[CNT_W-1:0]),
    .vbs        (cfg.vbs[CNT_W-1:0]),
    .vbe        (vbe_a),
    .winh       (cfg.winh[CNT_W-1:0]),
    .winv0      (cfg.winv0[CNT_W-1:0]),
    .winv1      (cfg.winv1[CNT_W-1:0]),
    .disp_en    (cfg.disp_en),
    .blank      (blank_a),
    .pixdbl     (cfg.pixdbl),
    .line_dbl   (cfg.line_dbl),
    .vid_en     (vid_en_a),
    .border_act (border_active),
    .win_act    (window_active),
    .win_x      (win_x),
    .win_y      (win_y),
    .hsync      (hsync),
    .vsync      (vsync)
  );
endmodule

// File: rtl/bwin_timing_chk.sv
module bwin_timing_chk #(
  parameter int CNT_W = 16,
  parameter int NREG  = 9
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [CNT_W-1:0]       hcount,
  input logic [CNT_W-1:0]       vcount,
  input logic [CNT_W-1:0]       htot_a,
  input logic                   pix_step,
  input logic                   full_rate_a,
  input logic                   load,
  input logic                   border_active,
  input logic                   window_active,
  input logic                   blank_a,
  input logic                   vid_en_a,
  input logic                   hsync,
  input logic                   vsync,
  input logic [NREG-1:0][31:0]  shadow_img,
  input logic [NREG-1:0][31:0]  active_img
);
  AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    pix_step && (hcount >= htot_a) |=> hcount == '0); // R2
  AST_H_INC: assert property (@(posedge clk) disable iff (!rst_n)
    pix_step && (hcount < htot_a) |=> hcount == $past(hcount) + 1'b1); // R2
  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_step |=> $stable(hcount) && $stable(vcount)); // R3
  AST_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    !full_rate_a && !load && pix_step |=> !pix_step); // R3
  AST_WIN_IN_BORDER: assert property (@(posedge clk) disable iff (!rst_n)
    window_active |-> border_active); // R5
  AST_BLANK_NO_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    blank_a |-> !window_active); // R6
  AST_SYNC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !vid_en_a |-> !hsync && !vsync); // R10
  AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> active_img == $past(shadow_img)); // R11
  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(active_img)); // R11
endmodule

bind bwin_timing bwin_timing_chk #(.CNT_W(CNT_W), .NREG(bwin_pkg::NUM_REGS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .hcount        (hcount),
  .vcount        (vcount),
  .htot_a        (htot_a),
  .pix_step      (pix_step),
  .full_rate_a   (full_rate_a),
  .load          (load),
  .border_active (border_active),
  .window_active (window_active),
  .blank_a       (blank_a),
  .vid_en_a      (vid_en_a),
  .hsync         (hsync),
  .vsync         (vsync),
  .shadow_img    (shadow_img),
  .active_img    (active_img)
);

// File: tb/bwin_timing_tb.sv
`timescale 1ns/1ps
module bwin_timing_tb_top;
  localparam int CW  = 16;
  localparam int AW  = 4;
  localparam int HSC = 8;
  localparam int VSL = 2;
  localparam int MASK = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [CW-1:0] hcount, vcount, win_x, win_y;
  logic          pix_step, field_odd, border_active, window_active, hsync, vsync;
  logic [23:0]   border_rgb;

  always #4 clk = ~clk;

  bwin_timing #(.CNT_W(CW), .ADDR_W(AW), .HSYNC_CLKS(HSC), .VSYNC_LINES(VSL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .hcount(hcount), .vcount(vcount), .pix_step(pix_step), .field_odd(field_odd),
    .border_active(border_active), .window_active(window_active), .win_x(win_x),
    .win_y(win_y), .border_rgb(border_rgb), .hsync(hsync), .vsync(vsync)
  );

  typedef struct packed {
    int h; int v; int st; int fd; int ba; int wa; int wx; int wy; int rgb; int hs; int vs;
  } exp_t;

  exp_t  q[$];
  string tq[$];
  string scn = "R1 reset";
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  // reference model state
  logic [31:0] m_sh [9];
  logic [31:0] m_ac [9];
  int mh, mv, mf, mph;

  function automatic int fld(input logic [31:0] w, input int hi);
    return hi ? int'(w[31:16]) & MASK : int'(w[15:0]) & MASK;
  endfunction

  always @(posedge clk) begin
    exp_t e;
    int htot, vtot, vlast, winv, st;
    bit ld, il, fr;
    if (!rst_n) begin
      for (int i = 0; i < 9; i++) begin m_sh[i] = '0; m_ac[i] = '0; end
      mh = 0; mv = 0; mf = 0; mph = 0;
    end else begin
      ld   = (mh == 0) && (mv == fld(m_ac[2], 0));
      htot = fld(m_ac[0], 0);
      vtot = fld(m_ac[0], 1);
      il   = m_ac[8][4];
      fr   = m_ac[7][23];
      st   = (fr || mph != 0) ? 1 : 0;
      mph  = 1 - mph;
      if (st != 0) begin
        if (mh >= htot) begin
          mh = 0;
          vlast = (il && mf != 0 && vtot != 0) ? vtot - 1 : vtot;
          if (mv >= vlast) begin mv = 0; mf = il ? 1 - mf : 0; end
          else mv = mv + 1;
        end else mh = mh + 1;
      end
      if (ld) for (int i = 0; i < 9; i++) m_ac[i] = m_sh[i];
      if (cfg_we && cfg_addr < 9) m_sh[cfg_addr] = cfg_wdata;
    end
    // expected outputs for the new state
    e.h  = mh; e.v = mv; e.fd = mf;
    e.st = (m_ac[7][23] || mph != 0) ? 1 : 0;
    e.ba = (m_ac[7][0] && mh >= fld(m_ac[1], 1) && mh < fld(m_ac[1], 0)
            && mv >= fld(m_ac[2], 1) && mv < fld(m_ac[2], 0)) ? 1 : 0;
    winv = mf != 0 ? fld(m_ac[4], 1) : fld(m_ac[4], 0);
    e.wa = (e.ba != 0 && !m_ac[6][3] && mh >= fld(m_ac[3], 0) && mv >= winv) ? 1 : 0;
    e.wx = 0; e.wy = 0;
    if (e.wa != 0) begin
      e.wx = m_ac[6][0] ? (mh - fld(m_ac[3], 0)) >> 1 : mh - fld(m_ac[3], 0);
      e.wy = m_ac[7][1] ? (mv - winv) >> 1 : mv - winv;
    end
    e.rgb = int'(m_ac[5][23:0]);
    e.hs  = (m_ac[8][8] && mh < HSC) ? 1 : 0;
    e.vs  = (m_ac[8][8] && mv < VSL) ? 1 : 0;
    q.push_back(e);
    tq.push_back(scn);
  end

  task automatic chk(input string req, input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", req, tag, act, expv, $time);
    end
  endtask

  // monitor: pops expected items and compares against the ports
  always @(negedge clk) begin
    exp_t  e;
    string t;
    if (q.size() > 0 && !done) begin
      e = q.pop_front();
      t = tq.pop_front();
      chk("R2 hcount", t, int'(hcount), e.h);
      chk("R2 vcount", t, int'(vcount), e.v);
      chk("R3 pix_step", t, int'(pix_step), e.st);
      chk("R9 field_odd", t, int'(field_odd), e.fd);
      chk("R4 border_active", t, int'(border_active), e.ba);
      chk("R5 window_active", t, int'(window_active), e.wa);
      chk("R7 win_x", t, int'(win_x), e.wx);
      chk("R8 win_y", t, int'(win_y), e.wy);
      chk("R12 border_rgb", t, int'(border_rgb), e.rgb);
      chk("R10 hsync", t, int'(hsync), e.hs);
      chk("R10 vsync", t, int'(vsync), e.vs);
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R2 R4 R5 R10 R12: base half-rate progressive configuration
    scn = "R2 R4 R5 R10 R12 R11 base";
    wr(0, {16'd19, 16'd39});
    wr(5, 32'h0012_AB34);
    wr(1, {16'd4, 16'd36});
    wr(2, {16'd2, 16'd17});
    wr(3, 32'd10);
    wr(4, {16'd6, 16'd5});
    wr(6, 32'd0);
    wr(7, 32'h1);
    wr(8, 32'h100);
    repeat (4000) @(negedge clk);
    // R7 R8: pixel and line doubling
    scn = "R7 R8 doubling";
    wr(6, 32'h1);
    wr(7, 32'h3);
    repeat (3500) @(negedge clk);
    // R6: forced blank keeps border, drops window
    scn = "R6 blank";
    wr(6, 32'h9);
    repeat (3500) @(negedge clk);
    // R11: writes to unused addresses leave the outputs untouched
    scn = "R11 ignored write";
    wr(12, 32'hFFFF_FFFF);
    wr(15, 32'hFFFF_FFFF);
    wr(9, 32'hFFFF_FFFF);
    repeat (2000) @(negedge clk);
    // R3 R9: full rate with interlaced long/short fields
    scn = "R3 R9 interlace full rate";
    wr(6, 32'h0);
    wr(7, 32'h0080_0001);
    wr(8, 32'h110);
    repeat (4000) @(negedge clk);
    // R4 R10: display and video disabled
    scn = "R4 R10 disabled";
    wr(7, 32'h0080_0000);
    wr(8, 32'h0);
    repeat (2000) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog actual=200000 cycles expected=fewer");
      finish_run();
    end
  end
endmodule